// File: doc/BRIEF.md
# Program Counter and Link Unit

This block keeps the fetch address and the saved return address of a simple fetcher for 32-bit, fixed-width instructions. Each fetch step moves the counter on by one instruction (4 bytes). A small shadow pipeline follows the fetched addresses two steps behind. This gives the address of the instruction now executing, and the counter value that this instruction reads, which is its own address plus 8.

Control requests from the executing instruction take effect on the clock edge. The requests are an absolute jump, a jump relative to the readable counter by a signed count of instructions, a call that saves the address after the executing instruction, and a return through the saved address. A separate `br_taken` input decides whether the three jump kinds are acted on. Every redirect squashes the two instructions in flight. Decode, memory, condition evaluation and exceptions are handled outside the block.

Top module: `pc_link_unit`

## Requirements
- R1: When `rst_n` is low, `fetch_addr`, `link_addr` and `exe_addr` are 0 and `exe_valid` is 0 at once, with no clock edge needed. After release, the first fetch is from address 0.
- R2: With `fetch_en` high and no acted-on request, `fetch_addr` grows by 4 at the edge. With `fetch_en` low and no acted-on request, `fetch_addr` holds.
- R3: On each plain fetch step, the shadow shifts. `exe_addr` is the address fetched two steps earlier, `exe_valid` is 1 once two steps follow the last redirect, and `pc_read` always equals `exe_addr + 8`.
- R4: A taken absolute jump loads `target_addr` into `fetch_addr` and clears `exe_valid`.
- R5: A taken relative jump loads `pc_read + 4*rel_ofs`, with `rel_ofs` read as a signed two's-complement instruction count.
- R6: A taken call loads `target_addr` into `fetch_addr` and `exe_addr + 4` into `link_addr` at the same edge.
- R7: A return loads `link_addr` into `fetch_addr` whatever `br_taken` is, and leaves `link_addr` unchanged.
- R8: When several requests are acted on together, return wins over call, call over absolute, and absolute over relative.
- R9: A jump or call request with `br_taken` low acts as a plain step: the address moves by 4 only if `fetch_en` is high, and `link_addr` is unchanged.
- R10: Bits [1:0] of `fetch_addr` and `link_addr` are always 0, even when the target is misaligned.
- R11: Request inputs take effect from the third rising edge after `rst_n` rises. Earlier edges leave the reset state in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_en | input | 1 | Advance fetch by one instruction |
| br_taken | input | 1 | Condition outcome for absolute, relative and call requests |
| abs_req | input | 1 | Absolute jump request |
| rel_req | input | 1 | Relative jump request |
| call_req | input | 1 | Call (jump and save return) request |
| ret_req | input | 1 | Return through saved address |
| target_addr | input | 32 | Target for absolute jump and call |
| rel_ofs | input | 24 | Signed instruction offset for relative jump |
| fetch_addr | output | 32 | Address of the next fetch |
| link_addr | output | 32 | Saved return address |
| exe_addr | output | 32 | Address of executing instruction |
| exe_valid | output | 1 | Executing slot holds a live instruction |
| pc_read | output | 32 | Counter value seen by the executing instruction |

## Verification
Every result is registered, so a request driven before edge k appears on `fetch_addr`, `link_addr` and `exe_valid` just after edge k. The one exception is `exe_valid`, which only returns to 1 after two more fetch steps. The bench changes inputs at the falling edge and reads outputs at the next falling edge, one full cycle later. An asynchronous reset is checked half a cycle after it is asserted, before any rising edge. After release, three idle rising edges are allowed before the first request.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

  typedef enum logic [2:0] {
    SEL_HOLD,
    SEL_INC,
    SEL_REL,
    SEL_ABS,
    SEL_CALL,
    SEL_RET
  } pcl_sel_e;

endpackage

// File: rtl/pcl_rst_sync.sv
module pcl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pcl_arbiter.sv
module pcl_arbiter
  import pcl_pkg::*;
(
  input  logic     fetch_en,
  input  logic     br_taken,
  input  logic     ret_req,
  input  logic     call_req,
  input  logic     abs_req,
  input  logic     rel_req,
  output pcl_sel_e sel,
  output logic     redirect
);

  always_comb begin
    if (ret_req)                   sel = SEL_RET;
    else if (br_taken && call_req) sel = SEL_CALL;
    else if (br_taken && abs_req)  sel = SEL_ABS;
    else if (br_taken && rel_req)  sel = SEL_REL;
    else if (fetch_en)             sel = SEL_INC;
    else                           sel = SEL_HOLD;
  end

  assign redirect = (sel == SEL_RET) || (sel == SEL_CALL) ||
                    (sel == SEL_ABS) || (sel == SEL_REL);

endmodule

// File: rtl/pcl_target.sv
module pcl_target
  import pcl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OFS_W      = 24,
  parameter int INSN_BYTES = 4
) (
  input  pcl_sel_e            sel,
  input  logic [ADDR_W-1:0]   cur_pc,
  input  logic [ADDR_W-1:0]   cur_link,
  input  logic [ADDR_W-1:0]   target,
  input  logic [OFS_W-1:0]    rel_ofs,
  input  logic [ADDR_W-1:0]   read_pc,
  input  logic [ADDR_W-1:0]   exe_pc,
  output logic [ADDR_W-1:0]   nxt_pc,
  output logic                link_we,
  output logic [ADDR_W-1:0]   link_val
);

  localparam int ALIGN_LSB = $clog2(INSN_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(INSN_BYTES) - ADDR_W'(1));

  logic [ADDR_W-1:0] ofs_ext;
  logic [ADDR_W-1:0] ofs_bytes;
  logic [ADDR_W-1:0] raw_pc;

  assign ofs_ext   = {{(ADDR_W-OFS_W){rel_ofs[OFS_W-1]}}, rel_ofs};
  assign ofs_bytes = ofs_ext << ALIGN_LSB;

  always_comb begin
    unique case (sel)
      SEL_INC:  raw_pc = cur_pc + STEP;
      SEL_REL:  raw_pc = read_pc + ofs_bytes;
      SEL_ABS:  raw_pc = target;
      SEL_CALL: raw_pc = target;
      SEL_RET:  raw_pc = cur_link;
      default:  raw_pc = cur_pc;
    endcase
  end

  assign nxt_pc   = raw_pc & ALIGN_MASK;
  assign link_we  = (sel == SEL_CALL);
  assign link_val = (exe_pc + STEP) & ALIGN_MASK;

endmodule

// File: rtl/pcl_shadow.sv
module pcl_shadow #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              flush,
  input  logic [ADDR_W-1:0] in_addr,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_valid
);

  logic [DEPTH-1:0][ADDR_W-1:0] addr_q, addr_d;
  logic [DEPTH-1:0]             vld_q, vld_d;
  logic                         en;

  assign en = step | flush;

  always_comb begin
    addr_d = addr_q;
    vld_d  = vld_q;
    if (flush) begin
      vld_d = '0;
    end else if (step) begin
      addr_d[0] = in_addr;
      vld_d[0]  = 1'b1;
      for (int i = 1; i < DEPTH; i++) begin
        addr_d[i] = addr_q[i-1];
        vld_d[i]  = vld_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vld_q  <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      vld_q  <= vld_d;
    end
  end

  assign out_addr  = addr_q[DEPTH-1];
  assign out_valid = vld_q[DEPTH-1];

endmodule

// File: rtl/pc_link_unit.sv
module pc_link_unit
  import pcl_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OFS_W       = 24,
  parameter int INSN_BYTES  = 4,
  parameter int AHEAD       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  input  logic              br_taken,
  input  logic              abs_req,
  input  logic              rel_req,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic [ADDR_W-1:0] target_addr,
  input  logic [OFS_W-1:0]  rel_ofs,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] link_addr,
  output logic [ADDR_W-1:0] exe_addr,
  output logic              exe_valid,
  output logic [ADDR_W-1:0] pc_read
);

  localparam logic [ADDR_W-1:0] READ_AHEAD = ADDR_W'(AHEAD * INSN_BYTES);

  logic              rst_q_n;
  pcl_sel_e          sel;
  logic              redirect;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] link_q, link_d;
  logic              link_we;
  logic [ADDR_W-1:0] link_val;
  logic              pc_en;

  pcl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  pcl_arbiter u_arb (
    .fetch_en (fetch_en),
    .br_taken (br_taken),
    .ret_req  (ret_req),
    .call_req (call_req),
    .abs_req  (abs_req),
    .rel_req  (rel_req),
    .sel      (sel),
    .redirect (redirect)
  );

  pcl_target #(
    .ADDR_W     (ADDR_W),
    .OFS_W      (OFS_W),
    .INSN_BYTES (INSN_BYTES)
  ) u_tgt (
    .sel      (sel),
    .cur_pc   (pc_q),
    .cur_link (link_q),
    .target   (target_addr),
    .rel_ofs  (rel_ofs),
    .read_pc  (pc_read),
    .exe_pc   (exe_addr),
    .nxt_pc   (pc_d),
    .link_we  (link_we),
    .link_val (link_val)
  );

  pcl_shadow #(
    .ADDR_W (ADDR_W),
    .DEPTH  (AHEAD)
  ) u_shadow (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .step      (sel == SEL_INC),
    .flush     (redirect),
    .in_addr   (pc_q),
    .out_addr  (exe_addr),
    .out_valid (exe_valid)
  );

  assign pc_en  = (sel != SEL_HOLD);
  assign link_d = link_we ? link_val : link_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      link_q <= '0;
    end else if (link_we) begin
      link_q <= link_d;
    end
  end

  assign fetch_addr = pc_q;
  assign link_addr  = link_q;
  assign pc_read    = exe_addr + READ_AHEAD;

endmodule

// File: rtl/pcl_checker.sv
module pcl_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_en,
  input logic              br_taken,
  input logic              abs_req,
  input logic              rel_req,
  input logic              call_req,
  input logic              ret_req,
  input logic [ADDR_W-1:0] target_addr,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [ADDR_W-1:0] link_addr,
  input logic [ADDR_W-1:0] exe_addr,
  input logic              exe_valid
);

  logic jump_on;
  logic any_redir;
  assign jump_on   = br_taken && (abs_req || rel_req || call_req);
  assign any_redir = ret_req || jump_on;

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && !any_redir) |=> fetch_addr == $past(fetch_addr) + 32'd4);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_en && !any_redir) |=> $stable(fetch_addr));

  a_r4_flush: assert property (@(posedge clk) disable iff (!rst_n)
    any_redir |=> !exe_valid);

  a_r6_call_link: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_req && br_taken && call_req) |=>
      (link_addr == $past(exe_addr) + 32'd4) &&
      (fetch_addr == ($past(target_addr) & ~32'd3)));

  a_r7_return: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |=> (fetch_addr == $past(link_addr)) && $stable(link_addr));

  a_r9_link_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(br_taken && call_req) |=> $stable(link_addr));

  a_r10_align: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr[1:0] == 2'b00) && (link_addr[1:0] == 2'b00));

endmodule

bind pc_link_unit pcl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .fetch_en    (fetch_en),
  .br_taken    (br_taken),
  .abs_req     (abs_req),
  .rel_req     (rel_req),
  .call_req    (call_req),
  .ret_req     (ret_req),
  .target_addr (target_addr),
  .fetch_addr  (fetch_addr),
  .link_addr   (link_addr),
  .exe_addr    (exe_addr),
  .exe_valid   (exe_valid)
);

// File: tb/sim_pc_link_unit.sv
module sim_pc_link_unit;

  logic        clk;
  logic        rst_n;
  logic        fetch_en, br_taken, abs_req, rel_req, call_req, ret_req;
  logic [31:0] target_addr;
  logic [23:0] rel_ofs;
  logic [31:0] fetch_addr, link_addr, exe_addr, pc_read;
  logic        exe_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pc_link_unit u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_en    (fetch_en),
    .br_taken    (br_taken),
    .abs_req     (abs_req),
    .rel_req     (rel_req),
    .call_req    (call_req),
    .ret_req     (ret_req),
    .target_addr (target_addr),
    .rel_ofs     (rel_ofs),
    .fetch_addr  (fetch_addr),
    .link_addr   (link_addr),
    .exe_addr    (exe_addr),
    .exe_valid   (exe_valid),
    .pc_read     (pc_read)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    fetch_en = 0; br_taken = 0; abs_req = 0; rel_req = 0;
    call_req = 0; ret_req = 0; target_addr = '0; rel_ofs = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      fetch_en = 1; tick(); idle();
    end
  endtask

  task automatic t_reset();
    idle();
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    fetch_en = 1;
    tick(); tick();
    chk("R11 no step before sync release", fetch_addr, 32'h0);
    idle(); tick();
    chk("R1 fetch_addr", fetch_addr, 32'h0);
    chk("R1 link_addr", link_addr, 32'h0);
    chk("R1 exe_valid", {31'b0, exe_valid}, 32'h0);
    chk("R3 pc_read at reset", pc_read, 32'h8);
  endtask

  task automatic t_increment();
    fetch_en = 1; tick(); idle();
    chk("R2 first step", fetch_addr, 32'h4);
    fetch_en = 1; tick(); idle();
    chk("R2 second step", fetch_addr, 32'h8);
    chk("R3 exe_valid", {31'b0, exe_valid}, 32'h1);
    chk("R3 exe_addr", exe_addr, 32'h0);
    chk("R3 pc_read", pc_read, 32'h8);
    fetch_en = 1; tick(); idle();
    chk("R3 exe_addr shifted", exe_addr, 32'h4);
    chk("R3 pc_read shifted", pc_read, 32'hC);
    tick();
    chk("R2 hold", fetch_addr, 32'hC);
    chk("R2 hold exe", exe_addr, 32'h4);
  endtask

  task automatic t_absolute();
    fetch_en = 1; abs_req = 1; br_taken = 1; target_addr = 32'h1000;
    tick(); idle();
    chk("R4 target", fetch_addr, 32'h1000);
    chk("R4 flush", {31'b0, exe_valid}, 32'h0);
    steps(2);
    chk("R4 refill addr", fetch_addr, 32'h1008);
    chk("R4 refill exe", exe_addr, 32'h1000);
    chk("R4 refill valid", {31'b0, exe_valid}, 32'h1);
  endtask

  task automatic t_relative();
    rel_req = 1; br_taken = 1; rel_ofs = 24'hFFFFFE;
    tick(); idle();
    chk("R5 negative offset", fetch_addr, 32'h1000);
    steps(2);
    rel_req = 1; br_taken = 1; rel_ofs = 24'd5;
    tick(); idle();
    chk("R5 positive offset", fetch_addr, 32'h101C);
  endtask

  task automatic t_call();
    steps(2);
    chk("R6 exe before call", exe_addr, 32'h101C);
    call_req = 1; br_taken = 1; target_addr = 32'h2003;
    tick(); idle();
    chk("R6 link", link_addr, 32'h1020);
    chk("R10 misaligned target", fetch_addr, 32'h2000);
  endtask

  task automatic t_not_taken();
    steps(2);
    fetch_en = 1; abs_req = 1; call_req = 1; rel_req = 1; rel_ofs = 24'd9;
    br_taken = 0; target_addr = 32'h5000;
    tick(); idle();
    chk("R9 untaken steps", fetch_addr, 32'h200C);
    chk("R9 link kept", link_addr, 32'h1020);
    chk("R9 exe shifted", exe_addr, 32'h2004);
    abs_req = 1; br_taken = 0; target_addr = 32'h5000;
    tick(); idle();
    chk("R9 untaken no fetch_en holds", fetch_addr, 32'h200C);
  endtask

  task automatic t_return();
    ret_req = 1; br_taken = 0;
    tick(); idle();
    chk("R7 return", fetch_addr, 32'h1020);
    chk("R7 link kept", link_addr, 32'h1020);
    chk("R7 flush", {31'b0, exe_valid}, 32'h0);
  endtask

  task automatic t_priority();
    steps(2);
    ret_req = 1; call_req = 1; abs_req = 1; br_taken = 1; target_addr = 32'h3000;
    tick(); idle();
    chk("R8 return beats call", fetch_addr, 32'h1020);
    chk("R8 call suppressed", link_addr, 32'h1020);
    steps(2);
    call_req = 1; abs_req = 1; rel_req = 1; br_taken = 1;
    target_addr = 32'h4000; rel_ofs = 24'd64;
    tick(); idle();
    chk("R8 call beats absolute", fetch_addr, 32'h4000);
    chk("R8 call link", link_addr, 32'h1024);
    abs_req = 1; rel_req = 1; br_taken = 1; target_addr = 32'h5000; rel_ofs = 24'd100;
    tick(); idle();
    chk("R8 absolute beats relative", fetch_addr, 32'h5000);
  endtask

  task automatic t_async_reset();
    steps(1);
    #1 rst_n = 0;
    #0.5;
    chk("R1 async fetch", fetch_addr, 32'h0);
    chk("R1 async link", link_addr, 32'h0);
    chk("R1 async exe", exe_addr, 32'h0);
    @(negedge clk);
    rst_n = 1;
    tick(); tick(); tick();
    steps(1);
    chk("R1 restart from zero", fetch_addr, 32'h4);
  endtask

  initial begin
    t_reset();
    t_increment();
    t_absolute();
    t_relative();
    t_call();
    t_not_taken();
    t_return();
    t_priority();
    t_async_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule